// File: doc/BRIEF.md
# Hiccup Overload Protection Sequencer

This block decides how one supply output reacts when its overcurrent comparator trips. In dynamic mode it runs a hiccup cycle. On an overload it switches the output off for a long rest interval. It then switches the output back on for a short trial window, and it repeats the pair until one whole trial window passes with the comparator quiet. Only then does it return to normal running and drop the overload flag. In static mode the output is never switched off. The current clamp limits the load, and the flag simply follows the comparator.

All timing is counted in ticks of an external millisecond timebase. The rest and trial lengths are parameters, with defaults of 900 and 20 ticks. The comparator input is assumed to be synchronized already. A pulse on the soft-start-done input clears the flag and returns the sequencer to normal running.

Top module: `ovl_hiccup_seq`

## Requirements
- R1: While and after the synchronous reset `rst`, `out_en` is 1 and `ovl_flag` is 0.
- R2: In dynamic mode (`mode_static`=0) during normal running, a cycle with both `tick` and `ovl_in` high makes `out_en` 0 and `ovl_flag` 1 from the next cycle on. `ovl_in` high without `tick` has no effect.
- R3: The rest interval lasts exactly OFF_TICKS ticks. `out_en` returns to 1 in the cycle after the OFF_TICKS-th tick following entry, and `ovl_in` is ignored during the rest interval.
- R4: The trial window lasts ON_TICKS ticks with `out_en`=1 and `ovl_flag`=1. If `ovl_in` was high on any tick of the window, the sequencer re-enters the rest interval after the ON_TICKS-th tick, even when the comparator was quiet on the last tick.
- R5: If `ovl_in` was low on every tick of the trial window, then after its ON_TICKS-th tick `ovl_flag` is 0, `out_en` stays 1 and normal running resumes.
- R6: In static mode (`mode_static`=1), `out_en` stays 1 and `ovl_flag` equals the value `ovl_in` had one cycle earlier.
- R7: When the mode changes from static to dynamic while `ovl_in` is high, the output stays enabled until the next tick and turns off in the cycle after that tick.
- R8: A cycle with `ss_done` high forces `ovl_flag` to 0 and `out_en` to 1 from the next cycle, clearing the sequence. This takes priority over both modes.
- R9: Switching to static mode during the rest interval re-enables the output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovl_in | input | 1 | Synchronized overload comparator |
| mode_static | input | 1 | 1 = static reporting, 0 = dynamic hiccup |
| ss_done | input | 1 | Soft-start completion pulse |
| tick | input | 1 | One-cycle timebase pulse (1 ms) |
| out_en | output | 1 | Output stage enable |
| ovl_flag | output | 1 | Overload flag for the host |

## Verification
The hardest situation to reach is a trial window that fails only because of a comparator pulse on an inner tick while its final tick is clean. The bench reaches it by driving the comparator tick by tick. It first fails one full rest interval, then asserts the comparator on the second trial tick only. It then checks that the output drops again after the last tick. Switching the mode in the middle of an overload is reached the same way: the bench holds the comparator high in static mode and clears the mode bit between ticks.

// File: rtl/ovl_hiccup_seq.sv
module ovl_hiccup_seq #(
  parameter int OFF_TICKS = 900,
  parameter int ON_TICKS  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic ovl_in,
  input  logic mode_static,
  input  logic ss_done,
  input  logic tick,
  output logic out_en,
  output logic ovl_flag
);

  localparam int CNT_MAX = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

  typedef enum logic [1:0] {S_RUN, S_OFF, S_RETRY} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          failed;

  wire hit      = tick && ovl_in;
  wire off_done = tick && (cnt == OFF_LAST);
  wire on_done  = tick && (cnt == ON_LAST);

  always_ff @(posedge clk) begin
    if (rst || ss_done) begin
      state    <= S_RUN;
      cnt      <= '0;
      failed   <= 1'b0;
      ovl_flag <= 1'b0;
    end else if (mode_static) begin
      state    <= S_RUN;
      cnt      <= '0;
      failed   <= 1'b0;
      ovl_flag <= ovl_in;
    end else begin
      case (state)
        S_RUN: begin
          ovl_flag <= hit;
          if (hit) begin
            state <= S_OFF;
            cnt   <= '0;
          end
        end
        S_OFF: begin
          if (off_done) begin
            state  <= S_RETRY;
            cnt    <= '0;
            failed <= 1'b0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RETRY: begin
          if (on_done) begin
            cnt    <= '0;
            failed <= 1'b0;
            if (failed || ovl_in) begin
              state <= S_OFF;
            end else begin
              state    <= S_RUN;
              ovl_flag <= 1'b0;
            end
          end else if (tick) begin
            cnt    <= cnt + 1'b1;
            failed <= failed | ovl_in;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign out_en = (state != S_OFF);

  // R2/R3: while the output rests, the overload must be reported
  p_off_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> ovl_flag);

  // R6: static mode never disables the output
  p_static_on_r6: assert property (@(posedge clk) disable iff (rst)
    mode_static |=> out_en);

  // R6: static flag tracks comparator with one cycle of delay
  p_static_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_static) && !$past(ss_done) && !$past(rst)) |-> (ovl_flag == $past(ovl_in)));

  // R5: in dynamic mode the flag never drops straight out of the rest interval
  p_no_clear_from_off_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ovl_flag) && !$past(mode_static) && !$past(ss_done)) |-> ($past(state) != S_OFF));

  // R3: counter stays below the longest interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(CNT_MAX));

  // R8: soft-start completion clears the flag
  p_ss_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ss_done |=> (!ovl_flag && out_en));

endmodule

// File: tb/test_ovl_hiccup_seq.sv
module test_ovl_hiccup_seq;
  localparam int OFF = 10;
  localparam int ON  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovl_in = 1'b0, mode_static = 1'b0, ss_done = 1'b0, tick = 1'b0;
  logic out_en, ovl_flag;
  int total = 0, bad = 0;

  ovl_hiccup_seq #(.OFF_TICKS(OFF), .ON_TICKS(ON)) i_ovl_hiccup_seq (
    .clk(clk), .rst(rst), .ovl_in(ovl_in), .mode_static(mode_static),
    .ss_done(ss_done), .tick(tick), .out_en(out_en), .ovl_flag(ovl_flag));

  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick_once(logic ov);
    @(negedge clk); tick = 1'b1; ovl_in = ov;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic trigger();
    tick_once(1'b1);
  endtask

  task automatic rest_through(string req, logic ov);
    for (int i = 0; i < OFF - 1; i++) begin
      tick_once(ov);
      chk(req, "out_en during rest", out_en, 1'b0);
    end
    tick_once(ov);
    chk(req, "out_en after rest", out_en, 1'b1);
    chk(req, "flag in trial", ovl_flag, 1'b1);
  endtask

  task automatic clean_trial();
    for (int i = 0; i < ON; i++) tick_once(1'b0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", "out_en in reset", out_en, 1'b1);
    chk("R1", "flag in reset", ovl_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_en after reset", out_en, 1'b1);
    chk("R1", "flag after reset", ovl_flag, 1'b0);
  endtask

  task automatic test_trigger();
    ovl_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "no trip without tick", out_en, 1'b1);
    trigger();
    chk("R2", "out_en after trip", out_en, 1'b0);
    chk("R2", "flag after trip", ovl_flag, 1'b1);
  endtask

  task automatic test_hiccup_fail();
    rest_through("R3", 1'b1);
    for (int i = 0; i < ON - 1; i++) begin
      tick_once(1'b1);
      chk("R4", "out_en in trial", out_en, 1'b1);
      chk("R4", "flag in trial", ovl_flag, 1'b1);
    end
    tick_once(1'b1);
    chk("R4", "out_en after failed trial", out_en, 1'b0);
  endtask

  task automatic test_clean();
    rest_through("R3", 1'b0);
    clean_trial();
    chk("R5", "flag after clean trial", ovl_flag, 1'b0);
    chk("R5", "out_en after clean trial", out_en, 1'b1);
    repeat (OFF + 2) tick_once(1'b0);
    chk("R5", "stays running", out_en, 1'b1);
  endtask

  task automatic test_glitch();
    trigger();
    rest_through("R3", 1'b0);
    tick_once(1'b0);
    tick_once(1'b1);
    for (int i = 0; i < ON - 2; i++) tick_once(1'b0);
    chk("R4", "inner hit fails trial", out_en, 1'b0);
    chk("R4", "flag kept", ovl_flag, 1'b1);
    rest_through("R3", 1'b0);
    clean_trial();
    chk("R5", "flag cleared after recovery", ovl_flag, 1'b0);
  endtask

  task automatic test_static();
    @(negedge clk); mode_static = 1'b1; ovl_in = 1'b1;
    @(negedge clk);
    chk("R6", "flag mirrors high", ovl_flag, 1'b1);
    repeat (OFF + 3) tick_once(1'b1);
    chk("R6", "out_en static overload", out_en, 1'b1);
    ovl_in = 1'b0;
    @(negedge clk);
    chk("R6", "flag mirrors low", ovl_flag, 1'b0);
  endtask

  task automatic test_mode_switch();
    ovl_in = 1'b1;
    @(negedge clk);
    mode_static = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7", "out_en before tick", out_en, 1'b1);
    tick_once(1'b1);
    chk("R7", "out_en after tick", out_en, 1'b0);
    mode_static = 1'b1;
    @(negedge clk);
    chk("R9", "static re-enables", out_en, 1'b1);
    chk("R9", "flag in static", ovl_flag, 1'b1);
    ovl_in = 1'b0;
    @(negedge clk);
    mode_static = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_softstart();
    trigger();
    chk("R8", "off before soft-start", out_en, 1'b0);
    ovl_in = 1'b1;
    ss_done = 1'b1;
    @(negedge clk); ss_done = 1'b0;
    chk("R8", "flag cleared", ovl_flag, 1'b0);
    chk("R8", "out_en restored", out_en, 1'b1);
    tick_once(1'b0);
    chk("R8", "running after soft-start", out_en, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_trigger();
    test_hiccup_fail();
    test_clean();
    test_glitch();
    test_static();
    test_mode_switch();
    test_softstart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule